// File: doc/BRIEF.md
# Receive Buffer with Stale-Data Interrupt

This block sits between an internal receive path and a host register port. Bytes arrive on a push strobe and are queued in a small first-in first-out store. The host reads the data location with a read strobe. The oldest byte is presented combinationally, and it is removed at the clock edge that ends the strobe. A fill-level flag asks for service once enough bytes have gathered.

A second interrupt source is a countdown timer that runs on a prescaled tick input. The timer restarts on every host read. If it reaches zero while any byte is still queued, a sticky stale-data flag is raised. This happens even when the fill level is below the service threshold, so that short trailing messages are still collected. The period comes from the low byte of a 16-bit setting register, and the upper byte of that register is reserved.

The interrupt output is a level: the OR of the fill-level flag and the stale-data flag.

Top module: `rx_fifo_tmo`

## Requirements
- R1: After reset the count is 0, the read data is 0, all flags and the interrupt are low, and the setting register reads 0x00FF (period 255 ticks).
- R2: Bytes are read out in the order they were pushed. `rd_data` shows the oldest queued byte, and the count follows accepted pushes and pops.
- R3: A push while the buffer holds DEPTH bytes and no read occurs is dropped and sets the sticky `ovf` bit. A push and a read in the same cycle on a full buffer are both accepted.
- R4: A read of an empty buffer returns 0 and leaves the count at 0. A push in that same cycle is stored.
- R5: `thr_flag` is high exactly while the count is at least THRESH.
- R6: A setting write stores bits [7:0] as the new period and restarts the timer from that period. Bits [15:8] are ignored and read back as 0.
- R7: The timer decrements by one on each cycle with `tick` high while the buffer is non-empty. It holds at zero and holds while the buffer is empty. A host read reloads it from the period.
- R8: One cycle after the timer is at zero with data queued, `tmo_flag` goes high. It stays high until a host read, and it is never high with an empty buffer.
- R9: `irq` is high exactly when `thr_flag` or `tmo_flag` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Push strobe from receive path |
| wr_data | input | 8 | Byte to push |
| rd_en | input | 1 | Host read of the data location |
| rd_data | output | 8 | Oldest queued byte, 0 when empty |
| tick | input | 1 | Single-cycle timebase pulse |
| cfg_wr | input | 1 | Write strobe for the setting register |
| cfg_wdata | input | 16 | Setting register write data |
| cfg_rdata | output | 16 | Setting register read back |
| count | output | 4 | Number of queued bytes |
| thr_flag | output | 1 | Fill-level flag |
| tmo_flag | output | 1 | Stale-data flag |
| ovf | output | 1 | Sticky overflow |
| irq | output | 1 | Interrupt level |

## Verification
The timeout path is driven in four ways:
- Ticks with a lone byte queued, which gives a timeout below the threshold.
- Ticks while the buffer is empty, which must not consume the period.
- Reads interleaved between ticks, which must restart the count.
- Setting writes in mid-count, which must reload the timer.

Fill-and-drain runs separate threshold behaviour from timeout behaviour. Pushes at full with and without a read separate a lossless swap from a dropped byte. A long random mix of all strobes, including a zero period, is compared every cycle against a queue-based model.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [1:0] {
    TMR_HOLD = 2'd0,
    TMR_LOAD_CFG = 2'd1,
    TMR_LOAD_RD = 2'd2,
    TMR_DEC = 2'd3
  } tmr_act_e;
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           push,
  input  logic [DATA_W-1:0]              push_data,
  input  logic                           pop,
  output logic [DATA_W-1:0]              head_data,
  output logic [$clog2(DEPTH+1)-1:0]     fill,
  output logic                           ovf_flag
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] fill_q, fill_d;
  logic          ovf_q, ovf_d;
  logic          take_pop, take_push, is_empty, is_full;

  assign is_empty  = (fill_q == '0);
  assign is_full   = (fill_q == CW'(DEPTH));
  assign take_pop  = pop && !is_empty;
  assign take_push = push && (!is_full || take_pop);

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    fill_d   = fill_q;
    ovf_d    = ovf_q;
    if (take_push)
      wr_ptr_d = (wr_ptr_q == AW'(DEPTH-1)) ? '0 : wr_ptr_q + 1'b1;
    if (take_pop)
      rd_ptr_d = (rd_ptr_q == AW'(DEPTH-1)) ? '0 : rd_ptr_q + 1'b1;
    fill_d = fill_q + CW'(take_push) - CW'(take_pop);
    if (push && !take_push)
      ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      fill_q   <= '0;
      ovf_q    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      fill_q   <= fill_d;
      ovf_q    <= ovf_d;
    end
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (take_push && (wr_ptr_q == AW'(i)))
          mem[i] <= push_data;
      end
    end
  endgenerate

  assign head_data = is_empty ? '0 : mem[rd_ptr_q];
  assign fill      = fill_q;
  assign ovf_flag  = ovf_q;

  AST_FULL_PUSH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (is_full && push && !pop) |=> (fill_q == CW'(DEPTH)) && ovf_q); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q); // R3
  AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (is_empty && pop && !push) |=> (fill_q == '0)); // R4
endmodule

// File: rtl/rxf_timer.sv
module rxf_timer
  import rxf_pkg::*;
#(
  parameter int unsigned PER_W   = 8,
  parameter int unsigned REG_W   = 16,
  parameter int unsigned PER_RST = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cfg_wr,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic             rd_strobe,
  input  logic             has_data,
  output logic [PER_W-1:0] period,
  output logic             tmo
);
  logic [PER_W-1:0] per_q, per_d, cnt_q, cnt_d;
  logic             tmo_q, tmo_d;
  tmr_act_e         act;

  always_comb begin
    if (cfg_wr)                              act = TMR_LOAD_CFG;
    else if (rd_strobe)                      act = TMR_LOAD_RD;
    else if (tick && has_data && cnt_q != '0) act = TMR_DEC;
    else                                     act = TMR_HOLD;
  end

  always_comb begin
    per_d = per_q;
    cnt_d = cnt_q;
    unique case (act)
      TMR_LOAD_CFG: begin
        per_d = cfg_wdata[PER_W-1:0];
        cnt_d = cfg_wdata[PER_W-1:0];
      end
      TMR_LOAD_RD: cnt_d = per_q;
      TMR_DEC:     cnt_d = cnt_q - 1'b1;
      default:     cnt_d = cnt_q;
    endcase
    if (rd_strobe || !has_data) tmo_d = 1'b0;
    else if (cnt_q == '0)       tmo_d = 1'b1;
    else                        tmo_d = tmo_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= PER_W'(PER_RST);
      cnt_q <= PER_W'(PER_RST);
      tmo_q <= 1'b0;
    end else begin
      per_q <= per_d;
      cnt_q <= cnt_d;
      tmo_q <= tmo_d;
    end
  end

  assign period = per_q;
  assign tmo    = tmo_q;

  AST_RELOAD_ON_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (cnt_q == $past(cfg_wdata[PER_W-1:0]))); // R6
  AST_HOLD_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (!has_data && !cfg_wr && !rd_strobe) |=> $stable(cnt_q)); // R7
  AST_TMO_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> !tmo_q); // R8
endmodule

// File: rtl/rx_fifo_tmo.sv
module rx_fifo_tmo #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned THRESH  = 4,
  parameter int unsigned PER_W   = 8,
  parameter int unsigned REG_W   = 16,
  parameter int unsigned PER_RST = 255
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       rd_en,
  output logic [DATA_W-1:0]          rd_data,
  input  logic                       tick,
  input  logic                       cfg_wr,
  input  logic [REG_W-1:0]           cfg_wdata,
  output logic [REG_W-1:0]           cfg_rdata,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       thr_flag,
  output logic                       tmo_flag,
  output logic                       ovf,
  output logic                       irq
);
  localparam int unsigned CW    = $clog2(DEPTH+1);
  localparam int unsigned RSV_W = REG_W - PER_W;

  logic [CW-1:0]    fill;
  logic [PER_W-1:0] period;
  logic             tmo;

  rxf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push(wr_en), .push_data(wr_data),
    .pop(rd_en), .head_data(rd_data), .fill(fill), .ovf_flag(ovf)
  );

  rxf_timer #(.PER_W(PER_W), .REG_W(REG_W), .PER_RST(PER_RST)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .rd_strobe(rd_en), .has_data(fill != '0),
    .period(period), .tmo(tmo)
  );

  assign count     = fill;
  assign thr_flag  = (fill >= CW'(THRESH));
  assign tmo_flag  = tmo;
  assign irq       = thr_flag | tmo;
  assign cfg_rdata = {{RSV_W{1'b0}}, period};

  AST_TMO_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |-> (fill != '0)); // R8
endmodule

// File: tb/tb_rx_fifo_tmo.sv
module tb_rx_fifo_tmo;
  localparam int DEPTH = 8;
  localparam int THRESH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, tick = 0, cfg_wr = 0;
  logic [7:0] wr_data = 0;
  logic [15:0] cfg_wdata = 0;
  logic [7:0] rd_data;
  logic [15:0] cfg_rdata;
  logic [3:0] count;
  logic thr_flag, tmo_flag, ovf, irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  rx_fifo_tmo dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .tick(tick), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .count(count),
    .thr_flag(thr_flag), .tmo_flag(tmo_flag), .ovf(ovf), .irq(irq)
  );

  always #4 clk = ~clk;

  // behavioural reference
  byte unsigned q[$];
  int m_per, m_tc;
  bit m_tmo, m_ovf;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_per = 255;
      m_tc = 255;
      m_tmo = 0;
      m_ovf = 0;
    end else begin
      int sz;
      bit popped;
      sz = q.size();
      popped = rd_en && sz > 0;
      if (rd_en || sz == 0) m_tmo = 0;
      else if (m_tc == 0) m_tmo = 1;
      if (cfg_wr) begin
        m_per = cfg_wdata[7:0];
        m_tc = m_per;
      end else if (rd_en) begin
        m_tc = m_per;
      end else if (tick && sz != 0 && m_tc != 0) begin
        m_tc--;
      end
      if (popped) void'(q.pop_front());
      if (wr_en) begin
        if (sz < DEPTH || popped) q.push_back(wr_data);
        else m_ovf = 1;
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int exp_thr;
      exp_thr = (q.size() >= THRESH);
      check("R2", "count", count, q.size());
      check("R2", "rd_data", rd_data, (q.size() > 0) ? q[0] : 0);
      check("R3", "ovf", ovf, m_ovf);
      check("R5", "thr_flag", thr_flag, exp_thr);
      check("R6", "cfg_rdata", cfg_rdata, m_per);
      check("R8", "tmo_flag", tmo_flag, m_tmo);
      check("R9", "irq", irq, exp_thr | m_tmo);
    end
  end

  task automatic step(bit p, byte unsigned d, bit r, bit t, bit w, logic [15:0] wd);
    wr_en = p; wr_data = d; rd_en = r; tick = t; cfg_wr = w; cfg_wdata = wd;
    @(negedge clk); #1;
    wr_en = 0; rd_en = 0; tick = 0; cfg_wr = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1", "count", count, 0);
    check("R1", "rd_data", rd_data, 0);
    check("R1", "cfg_rdata", cfg_rdata, 16'h00FF);
    check("R1", "flags", {thr_flag, tmo_flag, ovf, irq}, 0);

    // R2 order, three bytes below threshold
    step(1, 8'h11, 0, 0, 0, 0);
    step(1, 8'h22, 0, 0, 0, 0);
    step(1, 8'h33, 0, 0, 0, 0);
    check("R5", "thr below", thr_flag, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 0, 0);

    // R4 empty read, then push+read on empty
    step(0, 0, 1, 0, 0, 0);
    check("R4", "empty count", count, 0);
    check("R4", "empty data", rd_data, 0);
    step(1, 8'h5A, 1, 0, 0, 0);
    check("R4", "push on empty read", count, 1);
    check("R4", "stored byte", rd_data, 8'h5A);
    step(0, 0, 1, 0, 0, 0);

    // R3/R5 fill, overflow, swap at full
    for (int i = 0; i < DEPTH; i++) step(1, 8'(8'hA0 + i), 0, 0, 0, 0);
    check("R5", "thr full", thr_flag, 1);
    step(1, 8'hEE, 1, 0, 0, 0);
    check("R3", "swap at full no ovf", ovf, 0);
    check("R3", "swap count", count, DEPTH);
    step(1, 8'hFF, 0, 0, 0, 0);
    check("R3", "drop sets ovf", ovf, 1);
    check("R3", "drop count", count, DEPTH);
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 0, 0, 0);

    // R6 period write, reserved byte ignored
    step(0, 0, 0, 0, 1, 16'hAB05);
    check("R6", "cfg_rdata", cfg_rdata, 16'h0005);

    // R7 ticks while empty must not count
    for (int i = 0; i < 10; i++) step(0, 0, 0, 1, 0, 0);
    step(1, 8'h77, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0);
    check("R7", "no timeout before period", tmo_flag, 0);
    step(0, 0, 0, 1, 0, 0);
    check("R7", "timer zero, flag next cycle", tmo_flag, 0);
    step(0, 0, 0, 0, 0, 0);
    check("R8", "timeout below threshold", tmo_flag, 1);
    check("R9", "irq from timeout", irq, 1);
    for (int i = 0; i < 5; i++) step(0, 0, 0, 1, 0, 0);
    check("R8", "sticky", tmo_flag, 1);
    step(1, 8'h78, 1, 0, 0, 0);
    check("R8", "cleared by read", tmo_flag, 0);

    // R7 read restarts mid-count
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, 0);
    step(1, 8'h79, 1, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    check("R7", "restart on read", tmo_flag, 0);
    step(0, 0, 0, 0, 1, 16'h0003);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    check("R6", "reload on write", tmo_flag, 1);
    while (count != 0) step(0, 0, 1, 0, 0, 0);

    // random mix, occasional zero period
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 3) != 0, 8'($urandom), ($urandom % 4) == 0,
           ($urandom % 2) == 0, ($urandom % 200) == 0,
           16'($urandom % 12) | 16'($urandom << 8));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule